// File: doc/BRIEF.md
# Cumulative Row Boundary Decoder

This block turns a physical address into a chip-select for one of four SDRAM rows. Software programs only one value per row: that row's upper limit, counted in 16 MB units from the bottom of memory. A row's base is not stored anywhere. It is the highest limit reached by the rows below it, so the rows stack on top of each other with no gaps.

A row whose limit does not rise above that running top holds no memory. The decoder treats it as absent and never selects it. The decode from address to select, row index and hit flag is purely combinational. Writes to the limit registers land on the next clock edge.

The block also drives out each row's base and size in 16 MB units, so software can read back the layout it has built.

Top module: `row_boundary_decoder`

## Requirements
- R1: After reset, all four limit registers read as zero. Every row is then empty, every row size reads 0, and `hit` is 0 for every address. A write with `cfg_we` high updates row `cfg_row` with `cfg_data`, and the change is visible from the first clock edge after the write.
- R2: Only bits 6:0 of a written limit value are kept. Bit 7 has no effect on decode or on readback.
- R3: Row 0's base is 0. The base of each later row is the highest effective limit among the rows below it. The base readback reports this value in 16 MB units.
- R4: A row whose limit is less than or equal to its base is empty. An empty row reports size 0 and is never selected.
- R5: Let the address unit be address bits 30:24. An address whose unit is at or above row N's base and strictly below row N's limit selects row N. For that address, `row_sel` has only bit N set, `row_idx` equals N, and `hit` is 1.
- R6: An address with bit 31 set, or with a unit at or above the top of the highest populated row, gives `hit` = 0, `row_sel` = 0 and `row_idx` = 0.
- R7: A populated row's size readback is its limit minus its base, in 16 MB units.
- R8: Outputs follow a change of `addr` within the same cycle, with no clock edge in between.
- R9: At most one bit of `row_sel` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the limit registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a limit register |
| cfg_row | input | 2 | Row whose limit is written |
| cfg_data | input | 8 | New limit value; bits 6:0 are used |
| addr | input | 32 | Physical address to decode |
| row_sel | output | 4 | One-hot chip-select; bit N selects row N |
| row_idx | output | 2 | Binary index of the selected row (0 on a miss) |
| hit | output | 1 | High when the address falls in a populated row |
| row_base | output | 28 | Per-row base in 16 MB units; row N occupies bits 7N+6:7N |
| row_size | output | 28 | Per-row size in 16 MB units; same packing as row_base |

## Verification
The bench builds the decoder with its default parameters: four rows, an 8-bit limit register with a 7-bit unit, and a 32-bit address with 16 MB granularity. At these values the whole unit range of 128 steps is small, so the bench can probe every boundary exactly. That covers the last unit of a row, the first unit of the next, limits set equal or going backwards, and the full 2 GB ceiling where bit 31 alone decides a miss. Random register writes mixed with random addresses then push the reference model through many layouts with empty rows in every position.

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder #(
  parameter int ROWS     = 4,
  parameter int REG_W    = 8,
  parameter int UNIT_W   = 7,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 24,
  localparam int IDX_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_row,
  input  logic [REG_W-1:0]        cfg_data,
  input  logic [ADDR_W-1:0]       addr,
  output logic [ROWS-1:0]         row_sel,
  output logic [IDX_W-1:0]        row_idx,
  output logic                    hit,
  output logic [ROWS*UNIT_W-1:0]  row_base,
  output logic [ROWS*UNIT_W-1:0]  row_size
);

  localparam int TOP_BIT = GRAN_LSB + UNIT_W;

  logic [UNIT_W-1:0] lim_q [ROWS];
  logic [UNIT_W-1:0] top_c [ROWS+1];
  logic [UNIT_W-1:0] unit;
  logic              over;

  assign unit = addr[TOP_BIT-1:GRAN_LSB];

  generate
    if (ADDR_W > TOP_BIT) begin : g_over
      assign over = |addr[ADDR_W-1:TOP_BIT];
    end else begin : g_no_over
      assign over = 1'b0;
    end
    if (REG_W > UNIT_W) begin : g_hi
      logic unused_cfg_hi;
      assign unused_cfg_hi = ^cfg_data[REG_W-1:UNIT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) lim_q[i] <= '0;
    end else if (cfg_we && (32'(cfg_row) < ROWS)) begin
      lim_q[cfg_row] <= cfg_data[UNIT_W-1:0];
    end
  end

  assign top_c[0] = '0;

  generate
    for (genvar g = 0; g < ROWS; g++) begin : g_row
      logic present;
      assign present        = lim_q[g] > top_c[g];
      assign top_c[g+1]     = present ? lim_q[g] : top_c[g];
      assign row_base[g*UNIT_W +: UNIT_W] = top_c[g];
      assign row_size[g*UNIT_W +: UNIT_W] = top_c[g+1] - top_c[g];
      assign row_sel[g]     = !over && present && (unit >= top_c[g]) && (unit < lim_q[g]);
    end
  endgenerate

  always_comb begin
    row_idx = '0;
    for (int i = 0; i < ROWS; i++)
      if (row_sel[i]) row_idx = IDX_W'(i);
  end

  assign hit = |row_sel;

endmodule

// File: rtl/row_boundary_decoder_chk.sv
module row_boundary_decoder_chk #(
  parameter int ROWS     = 4,
  parameter int UNIT_W   = 7,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 24,
  parameter int IDX_W    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [ROWS-1:0]        row_sel,
  input logic [IDX_W-1:0]       row_idx,
  input logic                   hit,
  input logic [ROWS*UNIT_W-1:0] row_base,
  input logic [ROWS*UNIT_W-1:0] row_size
);
  localparam int TOP_BIT = GRAN_LSB + UNIT_W;
  logic [UNIT_W:0] unit_x;
  assign unit_x = {1'b0, addr[TOP_BIT-1:GRAN_LSB]};

  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_sel));
  a_r5_idx_agrees: assert property (@(posedge clk) disable iff (!rst_n) hit |-> row_sel[row_idx]);
  a_r6_miss_idx_zero: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> (row_idx == '0));
  a_r3_row0_base: assert property (@(posedge clk) disable iff (!rst_n) row_base[UNIT_W-1:0] == '0);

  generate
    if (ADDR_W > TOP_BIT) begin : g_hi
      a_r6_high_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr[ADDR_W-1:TOP_BIT]) |-> (row_sel == '0));
    end
    for (genvar g = 0; g < ROWS; g++) begin : g_row
      logic [UNIT_W:0] b, s;
      assign b = {1'b0, row_base[g*UNIT_W +: UNIT_W]};
      assign s = {1'b0, row_size[g*UNIT_W +: UNIT_W]};
      a_r4_empty_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (s == '0) |-> !row_sel[g]);
      a_r5_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel[g] |-> ((unit_x >= b) && (unit_x < b + s)));
      if (g < ROWS-1) begin : g_chain
        a_r3_base_chain: assert property (@(posedge clk) disable iff (!rst_n)
          {1'b0, row_base[(g+1)*UNIT_W +: UNIT_W]} == b + s);
      end
    end
  endgenerate
endmodule

bind row_boundary_decoder row_boundary_decoder_chk #(
  .ROWS(ROWS), .UNIT_W(UNIT_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .row_sel(row_sel), .row_idx(row_idx),
  .hit(hit), .row_base(row_base), .row_size(row_size)
);

// File: tb/row_boundary_decoder_bench.sv
module row_boundary_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_row = '0;
  logic [7:0]  cfg_data = '0;
  logic [31:0] addr = '0;
  logic [3:0]  row_sel;
  logic [1:0]  row_idx;
  logic        hit;
  logic [27:0] row_base, row_size;

  int n_chk = 0;
  int n_fail = 0;
  int mdl [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  row_boundary_decoder u_row_boundary_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_data(cfg_data),
    .addr(addr), .row_sel(row_sel), .row_idx(row_idx), .hit(hit),
    .row_base(row_base), .row_size(row_size)
  );

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 4; i++) mdl[i] <= 0;
    else if (cfg_we) mdl[cfg_row] <= int'(cfg_data);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int top, lim, unit, e_idx;
    int e_base [4];
    int e_size [4];
    logic [3:0] e_sel;
    top = 0;
    e_sel = '0;
    e_idx = 0;
    unit = int'(addr[30:24]);
    for (int i = 0; i < 4; i++) begin
      lim = mdl[i] % 128;
      e_base[i] = top;
      e_size[i] = (lim > top) ? lim - top : 0;
      if (lim > top) begin
        if (!addr[31] && unit >= top && unit < lim) begin
          e_sel[i] = 1'b1;
          e_idx = i;
        end
        top = lim;
      end
    end
    chk(e_sel != 0 ? "R5 row_sel" : "R6 row_sel", 64'(row_sel), 64'(e_sel));
    chk(e_sel != 0 ? "R5 row_idx" : "R6 row_idx", 64'(row_idx), 64'(e_idx));
    chk(e_sel != 0 ? "R5 hit" : "R6 hit", 64'(hit), 64'(e_sel != 0));
    chk("R9 select count", 64'($countones(row_sel) <= 1), 64'(1));
    for (int i = 0; i < 4; i++) begin
      chk("R3 base", 64'(row_base[i*7 +: 7]), 64'(e_base[i]));
      chk(e_size[i] == 0 ? "R4 empty size" : "R7 size", 64'(row_size[i*7 +: 7]), 64'(e_size[i]));
    end
  endtask

  task automatic step(input logic we, input int row, input int data, input logic [31:0] a);
    @(posedge clk);
    #1;
    cfg_we = we;
    cfg_row = 2'(row);
    cfg_data = 8'(data);
    addr = a;
    #2;
    compare_all();
  endtask

  task automatic wr(input int row, input int data);
    step(1'b1, row, data, addr);
    step(1'b0, 0, 0, addr);
  endtask

  function automatic logic [31:0] at(input int u, input int lo);
    return {1'b0, 7'(u), 24'(lo)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state: all sizes zero, no hit anywhere
    step(1'b0, 0, 0, 32'h0);
    chk("R1 reset sizes", 64'(row_size), 64'(0));
    chk("R1 reset hit", 64'(hit), 64'(0));
    step(1'b0, 0, 0, 32'h7FFF_FFFF);
    chk("R1 reset hit top", 64'(hit), 64'(0));

    // R1 write lands at next edge: row0 limit 2, row1 6, row2 6 (empty), row3 0x26
    step(1'b1, 0, 2, at(1, 0));
    chk("R1 before edge", 64'(hit), 64'(0));
    step(1'b0, 0, 0, at(1, 0));
    chk("R1 after edge", 64'(row_sel), 64'(4'b0001));
    wr(1, 6);
    wr(2, 6);
    wr(3, 38);
    // boundaries
    step(1'b0, 0, 0, at(1, 24'hFF_FFFF));
    chk("R5 last unit row0", 64'(row_idx), 64'(0));
    step(1'b0, 0, 0, at(2, 0));
    chk("R5 first unit row1", 64'(row_sel), 64'(4'b0010));
    step(1'b0, 0, 0, at(6, 0));
    chk("R4 empty row2 skipped", 64'(row_sel), 64'(4'b1000));
    chk("R4 empty size", 64'(row_size[14 +: 7]), 64'(0));
    step(1'b0, 0, 0, at(38, 0));
    chk("R6 above top", 64'(hit), 64'(0));
    // R8: combinational change of addr without a clock
    addr = at(3, 5);
    #1;
    chk("R8 same cycle", 64'(row_sel), 64'(4'b0010));
    // R2: bit 7 ignored
    wr(0, 8'h84);
    chk("R2 bit7 ignored size", 64'(row_size[6:0]), 64'(4));
    // R4: going backwards
    wr(1, 3);
    chk("R4 backward limit empty", 64'(row_size[13:7]), 64'(0));
    // full range and bit 31
    wr(3, 127);
    step(1'b0, 0, 0, at(126, 0));
    chk("R5 top unit", 64'(row_idx), 64'(3));
    step(1'b0, 0, 0, 32'hA000_0000);
    chk("R6 bit31 miss", 64'(row_sel), 64'(0));
    // sweep every unit
    for (int u = 0; u < 128; u++) step(1'b0, 0, 0, at(u, u * 3));
    // random
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) == 0, int'($urandom % 4), int'($urandom % 256), $urandom);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule